// File: doc/BRIEF.md
# External Interrupt Request Latch

This block turns one active-low external interrupt pin into a request flag for an interrupt controller. The pin arrives asynchronously. It passes through a chain of synchronizing flops before any decision is made on it. A trigger-type control bit chooses between two kinds of sensing:

- **Falling-edge sensing:** a high-to-low transition is latched in a flag. The flag holds until the controller acknowledges it.
- **Low-level sensing:** the request simply follows the synchronized pin. It ends only when the outside source releases the pin.

Software can write the flag directly. A flag set this way raises a request in either mode. The request output also serves as the status bit that software reads.

A chip places one instance per external interrupt line, typically two. Enables, priority and vectoring live in the controller, not here.

Top module: `xirq_request_unit`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge), req_o is 0 and the trigger type is low-level sensing (mode bit 0), so a low pin raises a request without any configuration write.
- R2: In low-level mode, req_o goes to 1 at the second rising edge after pin_n_i falls, and back to 0 at the second rising edge after pin_n_i rises, given no latched flag.
- R3: In low-level mode, an ack_i pulse does not remove the request while the synchronized pin is still low.
- R4: With mode bit 1 (falling-edge sensing), a high-to-low pin transition sets the flag at the third rising edge after the pin falls. The flag stays set after the pin returns high.
- R5: In falling-edge mode, an ack_i pulse with no new edge clears the flag at that rising edge.
- R6: When a falling edge and ack_i fall on the same rising edge, the flag ends up set.
- R7: A software write (sw_wr_i high) loads sw_wdata_i into the flag at that rising edge. A written 1 raises req_o in either mode. A written 0 clears a latched flag but does not hide a low pin in low-level mode.
- R8: In low-level mode, a low pulse on the pin is not latched: req_o returns to 0 once the pin is high again.
- R9: In falling-edge mode, a pin held low after an acknowledge raises no further request until it goes high and falls again.
- R10: The trigger mode bit is loaded from cfg_wdata_i at a rising edge with cfg_wr_i high, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_n_i | input | 1 | Asynchronous external interrupt pin, active low |
| cfg_wr_i | input | 1 | Write strobe for the trigger mode bit |
| cfg_wdata_i | input | 1 | Trigger mode: 1 falling edge, 0 low level |
| ack_i | input | 1 | One-cycle acknowledge from the interrupt controller |
| sw_wr_i | input | 1 | Software write strobe for the request flag |
| sw_wdata_i | input | 1 | Value written into the request flag |
| req_o | output | 1 | Request to the controller, also the readable status bit |

## Verification
The pin is driven in several shapes, and each shape separates one behaviour from another:

- **Short low pulse:** in low-level mode it shows that nothing is latched. In edge mode it shows that an event is.
- **Long low hold followed by an acknowledge:** in level mode the request stays up. In edge mode it drops and does not come back while the pin is still low.
- **Edge and acknowledge on the same clock:** this is lined up deliberately, to tell "set wins" apart from "clear wins".

Software writes of 0 and 1 are tried in both modes, with the pin high and with it low. This separates the stored flag from the live level term. A mid-run reset shows that both the flag and the mode bit return to their reset values.

// File: rtl/xirq_pkg.sv
// Package: shared types and defaults for the external interrupt request latch.
// Assumes: the pin is active low and idles high.
package xirq_pkg;
    typedef enum logic {
        TRIG_LEVEL = 1'b0,
        TRIG_FALL  = 1'b1
    } xirq_trig_e;

    localparam int  XIRQ_SYNC_DEF = 2;
    localparam logic XIRQ_PIN_IDLE = 1'b1;
endpackage

// File: rtl/xirq_sync.sv
// Module: multi-flop synchronizer for one asynchronous pin.
// Assumes: STAGES >= 2; the reset value is the pin's idle level, so that no
// false request appears while the chain fills.
module xirq_sync #(
    parameter int   STAGES = 2,
    parameter logic IDLE   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] chain_q;

    // Shift the raw pin through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{IDLE}};
        else        chain_q <= {chain_q[TOP-1:0], async_i};
    end

    assign sync_o = chain_q[TOP];
endmodule

// File: rtl/xirq_fall_det.sv
// Module: falling-edge detector on the synchronized pin.
// Assumes: the input is already synchronous; fall_o is a one-cycle event,
// gated off when edge sensing is not selected.
module xirq_fall_det #(
    parameter logic IDLE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic cur_i,
    output logic fall_o
);
    logic prev_q;

    // Keep the previous synchronized sample.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= IDLE;
        else        prev_q <= cur_i;
    end

    assign fall_o = en_i & prev_q & ~cur_i;

    // R4
    fall_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);
endmodule

// File: rtl/xirq_flag.sv
// Module: latched request flag.
// Assumes: an edge event always sets the flag; otherwise a software write
// loads it; otherwise an acknowledge clears it.
module xirq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic ack_i,
    input  logic sw_wr_i,
    input  logic sw_wdata_i,
    output logic flag_o
);
    logic flag_q;
    logic flag_d;

    // Next-state selection: set by event dominates write and acknowledge.
    always_comb begin
        if (evt_i)        flag_d = 1'b1;
        else if (sw_wr_i) flag_d = sw_wdata_i;
        else if (ack_i)   flag_d = 1'b0;
        else              flag_d = flag_q;
    end

    // Flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> !flag_q);
    // R6
    edge_ack_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i && ack_i) |=> flag_q);
    // R5
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !evt_i && !sw_wr_i) |=> !flag_q);
    // R7
    sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr_i && sw_wdata_i) |=> flag_q);
endmodule

// File: rtl/xirq_request_unit.sv
// Module: external interrupt request latch (top).
// Assumes: pin_n_i is asynchronous and active low. Mode bit 1 selects
// falling-edge sensing with a latched flag; mode bit 0 selects low-level
// sensing, where the live synchronized level also drives the request.
module xirq_request_unit
    import xirq_pkg::*;
#(
    parameter int SYNC_STAGES = XIRQ_SYNC_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n_i,
    input  logic cfg_wr_i,
    input  logic cfg_wdata_i,
    input  logic ack_i,
    input  logic sw_wr_i,
    input  logic sw_wdata_i,
    output logic req_o
);
    xirq_trig_e mode_q;
    logic       pin_s;
    logic       fall_evt;
    logic       flag;
    logic       level_req;

    // Trigger mode register, written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)        mode_q <= TRIG_LEVEL;
        else if (cfg_wr_i) mode_q <= xirq_trig_e'(cfg_wdata_i);
    end

    xirq_sync #(
        .STAGES (SYNC_STAGES),
        .IDLE   (XIRQ_PIN_IDLE)
    ) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_n_i),
        .sync_o  (pin_s)
    );

    xirq_fall_det #(
        .IDLE (XIRQ_PIN_IDLE)
    ) i_fall (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (mode_q == TRIG_FALL),
        .cur_i  (pin_s),
        .fall_o (fall_evt)
    );

    xirq_flag i_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (fall_evt),
        .ack_i      (ack_i),
        .sw_wr_i    (sw_wr_i),
        .sw_wdata_i (sw_wdata_i),
        .flag_o     (flag)
    );

    // Live level term, present only in low-level mode.
    assign level_req = (mode_q == TRIG_LEVEL) & ~pin_s;
    assign req_o     = flag | level_req;

    // R3
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && mode_q == TRIG_LEVEL && !pin_s) |-> req_o);
    // R10
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr_i |=> $stable(mode_q));
endmodule

// File: tb/test_xirq_request_unit.sv
`timescale 1ns/100ps
module test_xirq_request_unit;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pin_n = 1'b1;
    logic cfg_wr = 1'b0, cfg_wdata = 1'b0;
    logic ack = 1'b0;
    logic sw_wr = 1'b0, sw_wdata = 1'b0;
    logic req;
    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    xirq_request_unit i_xirq_request_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_n_i     (pin_n),
        .cfg_wr_i    (cfg_wr),
        .cfg_wdata_i (cfg_wdata),
        .ack_i       (ack),
        .sw_wr_i     (sw_wr),
        .sw_wdata_i  (sw_wdata),
        .req_o       (req)
    );

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic set_mode(input logic v);
        cfg_wr = 1'b1; cfg_wdata = v; step();
        cfg_wr = 1'b0; step();
    endtask

    task automatic pulse_ack();
        ack = 1'b1; step(); ack = 1'b0;
    endtask

    task automatic sw_write(input logic v);
        sw_wr = 1'b1; sw_wdata = v; step(); sw_wr = 1'b0;
    endtask

    task automatic t_reset();
        step(2);
        chk("R1 req during reset", req, 1'b0);
        rst_n = 1'b1; step();
        chk("R1 req after reset", req, 1'b0);
    endtask

    task automatic t_level_follow();
        pin_n = 1'b0; step();
        chk("R2 level one edge", req, 1'b0);
        step();
        chk("R2 level two edges (R1 default mode)", req, 1'b1);
        pin_n = 1'b1; step();
        chk("R2 release one edge", req, 1'b1);
        step();
        chk("R2 release two edges", req, 1'b0);
    endtask

    task automatic t_level_ack();
        pin_n = 1'b0; step(3);
        pulse_ack(); step();
        chk("R3 ack in level mode", req, 1'b1);
        pin_n = 1'b1; step(3);
        chk("R3 released after ack", req, 1'b0);
    endtask

    task automatic t_level_no_latch();
        pin_n = 1'b0; step(3);
        pin_n = 1'b1; step(3);
        chk("R8 pulse not latched", req, 1'b0);
    endtask

    task automatic t_edge_set();
        set_mode(1'b1);
        chk("R10 mode write idle", req, 1'b0);
        pin_n = 1'b0; step(2);
        chk("R4 edge two edges", req, 1'b0);
        step();
        chk("R4 edge three edges", req, 1'b1);
        pin_n = 1'b1; step(4);
        chk("R4 latched after release", req, 1'b1);
    endtask

    task automatic t_edge_ack();
        pulse_ack();
        chk("R5 ack clears flag", req, 1'b0);
    endtask

    task automatic t_edge_held();
        pin_n = 1'b0; step(3);
        chk("R9 first event", req, 1'b1);
        pulse_ack(); step(5);
        chk("R9 held low no retrigger", req, 1'b0);
        pin_n = 1'b1; step(3);
        chk("R9 release no event", req, 1'b0);
    endtask

    task automatic t_edge_ack_same();
        pin_n = 1'b0; step(2);
        ack = 1'b1; step(); ack = 1'b0;
        chk("R6 edge and ack together", req, 1'b1);
        pulse_ack();
        pin_n = 1'b1; step(3);
        chk("R6 cleared afterwards", req, 1'b0);
    endtask

    task automatic t_sw();
        sw_write(1'b1);
        chk("R7 write 1 edge mode", req, 1'b1);
        sw_write(1'b0);
        chk("R7 write 0 edge mode", req, 1'b0);
        set_mode(1'b0);
        sw_write(1'b1);
        chk("R7 write 1 level mode", req, 1'b1);
        pulse_ack();
        chk("R7 ack clears written flag", req, 1'b0);
        pin_n = 1'b0; step(3);
        sw_write(1'b0);
        chk("R7 write 0 keeps live level", req, 1'b1);
        pin_n = 1'b1; step(3);
        chk("R7 idle after release", req, 1'b0);
    endtask

    task automatic t_mid_reset();
        set_mode(1'b1);
        sw_write(1'b1);
        rst_n = 1'b0; step();
        chk("R1 reset clears flag", req, 1'b0);
        rst_n = 1'b1; step();
        pin_n = 1'b0; step(2);
        chk("R1 mode back to level", req, 1'b1);
        pin_n = 1'b1; step(3);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        step();
        t_reset();
        t_level_follow();
        t_level_ack();
        t_level_no_latch();
        t_edge_set();
        t_edge_ack();
        t_edge_held();
        t_edge_ack_same();
        t_sw();
        t_mid_reset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule